// File: doc/BRIEF.md
# Floating-Point Compare and Classify Unit

This block compares two IEEE-754 double-precision operands and returns a 4-bit condition code. The code has one bit each for less-than, greater-than, equal and unordered. A legal compare writes the code to two places. One is a condition-register field, chosen by a target index. The other is the condition-code slice of the floating-point status word.

The unit has two compare flavours. The unordered compare treats a NaN operand as an ordinary unordered result. The ordered compare raises a trap when it meets a NaN and writes nothing. A third operation classifies a single value into the same kind of code and updates only the status slice.

Ordering uses the sign and magnitude of the raw bit patterns, so no floating-point arithmetic is involved. Every result is registered and appears one cycle after the issuing strobe, together with a one-cycle done pulse.

Top module: `fp_cmp_unit`

## Requirements
- R1: In either compare operation, if any operand is a NaN (exponent all ones, fraction nonzero), the code is 4'b0001 (unordered).
- R2: For non-NaN operands, a compare gives 4'b1000 when A < B, 4'b0100 when A > B and 4'b0010 when A == B. Ordering follows numeric value, including subnormals.
- R3: Positive zero and negative zero compare equal. Infinities order by their sign against every finite value and against each other.
- R4: An ordered compare (op_i = 2'b01) with a NaN operand asserts trap_o together with done_o, and keeps cr_we_o and st_we_o low.
- R5: An unordered compare (op_i = 2'b00) never traps; when legal it asserts both cr_we_o and st_we_o, including for NaN operands.
- R6: For compares, fld_o equals crf_sel_i[4:2]. A crf_sel_i whose low two bits are not 00 makes the operation illegal: illegal_o is asserted and trap_o, cr_we_o and st_we_o all stay low.
- R7: Whenever st_we_o is asserted, stat_o carries the value written into status bits 15:11. Bit 4 of stat_o (the class bit) is 0 and bits 3:0 equal code_o.
- R8: Classification (op_i = 2'b10) of operand A gives 4'b1000 for negative values, 4'b0100 for positive values, 4'b0010 for either zero and 4'b0101 for a NaN. It asserts st_we_o only, never traps, and is unaffected by crf_sel_i.
- R9: All outputs update in the cycle after valid_i is sampled. done_o is a one-cycle pulse, and cr_we_o, st_we_o, trap_o and illegal_o are high only while done_o is high.
- R10: op_i = 2'b11 is reserved: it asserts illegal_o and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Issue strobe for one operation |
| op_i | input | 2 | 00 unordered compare, 01 ordered compare, 10 classify A, 11 reserved |
| a_i | input | 64 | Operand A (double-precision bit pattern) |
| b_i | input | 64 | Operand B (double-precision bit pattern) |
| crf_sel_i | input | 5 | Raw target field selector; must be a multiple of 4 |
| done_o | output | 1 | One-cycle completion pulse |
| code_o | output | 4 | Condition code {lt, gt, eq, un} |
| fld_o | output | 3 | Condition-register field index |
| cr_we_o | output | 1 | Write enable for the condition-register field |
| st_we_o | output | 1 | Write enable for status bits 15:11 |
| stat_o | output | 5 | Value for status bits 15:11 ({class, code}) |
| trap_o | output | 1 | Invalid-operation trap from ordered compare |
| illegal_o | output | 1 | Illegal selector or reserved operation |

## Verification
The hardest case to reach from the ports is a pair of operands whose order depends on more than the magnitude bits. Examples are two zeros of opposite sign, a subnormal against zero, two negative values whose magnitude order is the reverse of their numeric order, and signalling versus quiet NaNs of either sign. The bench covers these by sweeping every pair from a list of special bit patterns through both compare operations. The expected order comes from the real-valued interpretation of the same bits. A second sweep walks all 32 selector values for both compare flavours, so that the illegal path and the trap path meet each other.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

  typedef enum logic [1:0] {
    OP_UCMP  = 2'b00,
    OP_OCMP  = 2'b01,
    OP_CLASS = 2'b10,
    OP_RSVD  = 2'b11
  } fpc_op_e;

  // condition code layout {lt, gt, eq, un}
  localparam int CODE_W = 4;
  localparam logic [CODE_W-1:0] CC_LT = 4'b1000;
  localparam logic [CODE_W-1:0] CC_GT = 4'b0100;
  localparam logic [CODE_W-1:0] CC_EQ = 4'b0010;
  localparam logic [CODE_W-1:0] CC_UN = 4'b0001;

endpackage

// File: rtl/fpc_opnd_dec.sv
module fpc_opnd_dec #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic [EXP_W+FRAC_W:0]   val_i,
  output logic                    sign_o,
  output logic                    nan_o,
  output logic                    zero_o,
  output logic [EXP_W+FRAC_W-1:0] mag_o
);
  localparam int MAG_W = EXP_W + FRAC_W;

  logic [EXP_W-1:0]  expo;
  logic [FRAC_W-1:0] frac;

  always_comb begin
    sign_o = val_i[MAG_W];
    mag_o  = val_i[MAG_W-1:0];
    expo   = val_i[MAG_W-1:FRAC_W];
    frac   = val_i[FRAC_W-1:0];
    nan_o  = (&expo) && (|frac);
    zero_o = ~|mag_o;
  end
endmodule

// File: rtl/fpc_order.sv
module fpc_order #(
  parameter int MAG_W = 63
) (
  input  logic             sa_i,
  input  logic             za_i,
  input  logic [MAG_W-1:0] ma_i,
  input  logic             sb_i,
  input  logic             zb_i,
  input  logic [MAG_W-1:0] mb_i,
  output logic [3:0]       code_o
);
  import fpc_pkg::*;

  logic same_bits, eq, a_below, mag_lt, mag_gt;

  always_comb begin
    mag_lt    = ma_i < mb_i;
    mag_gt    = mb_i < ma_i;
    same_bits = (sa_i == sb_i) && (ma_i == mb_i);
    eq        = same_bits || (za_i && zb_i);
    if (sa_i != sb_i)
      a_below = sa_i;
    else if (!sa_i)
      a_below = mag_lt;
    else
      a_below = mag_gt;
    if (eq)
      code_o = CC_EQ;
    else if (a_below)
      code_o = CC_LT;
    else
      code_o = CC_GT;
  end
endmodule

// File: rtl/fpc_class_code.sv
module fpc_class_code (
  input  logic       sign_i,
  input  logic       nan_i,
  input  logic       zero_i,
  output logic [3:0] code_o
);
  import fpc_pkg::*;

  always_comb begin
    if (nan_i)
      code_o = CC_GT | CC_UN;
    else if (zero_i)
      code_o = CC_EQ;
    else if (sign_i)
      code_o = CC_LT;
    else
      code_o = CC_GT;
  end
endmodule

// File: rtl/fp_cmp_unit.sv
module fp_cmp_unit #(
  parameter int EXP_W   = 11,
  parameter int FRAC_W  = 52,
  parameter int SEL_W   = 5,
  parameter int ALIGN_W = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     valid_i,
  input  logic [1:0]               op_i,
  input  logic [EXP_W+FRAC_W:0]    a_i,
  input  logic [EXP_W+FRAC_W:0]    b_i,
  input  logic [SEL_W-1:0]         crf_sel_i,
  output logic                     done_o,
  output logic [3:0]               code_o,
  output logic [SEL_W-ALIGN_W-1:0] fld_o,
  output logic                     cr_we_o,
  output logic                     st_we_o,
  output logic [4:0]               stat_o,
  output logic                     trap_o,
  output logic                     illegal_o
);
  import fpc_pkg::*;

  localparam int DW    = 1 + EXP_W + FRAC_W;
  localparam int MAG_W = DW - 1;
  localparam int FLD_W = SEL_W - ALIGN_W;

  logic [DW-1:0]    opnd   [2];
  logic             sgn    [2];
  logic             nan    [2];
  logic             zer    [2];
  logic [MAG_W-1:0] mag    [2];

  assign opnd[0] = a_i;
  assign opnd[1] = b_i;

  for (genvar gi = 0; gi < 2; gi++) begin : g_dec
    fpc_opnd_dec #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_dec (
      .val_i  (opnd[gi]),
      .sign_o (sgn[gi]),
      .nan_o  (nan[gi]),
      .zero_o (zer[gi]),
      .mag_o  (mag[gi])
    );
  end

  logic [3:0] ord_code, cls_code;

  fpc_order #(.MAG_W(MAG_W)) u_order (
    .sa_i   (sgn[0]), .za_i (zer[0]), .ma_i (mag[0]),
    .sb_i   (sgn[1]), .zb_i (zer[1]), .mb_i (mag[1]),
    .code_o (ord_code)
  );

  fpc_class_code u_class (
    .sign_i (sgn[0]),
    .nan_i  (nan[0]),
    .zero_i (zer[0]),
    .code_o (cls_code)
  );

  fpc_op_e    op;
  logic       is_cmp, any_nan, misalign, ill_n, trap_n, crw_n, stw_n;
  logic [3:0] code_n;

  always_comb begin
    op       = fpc_op_e'(op_i);
    is_cmp   = (op == OP_UCMP) || (op == OP_OCMP);
    any_nan  = nan[0] || nan[1];
    misalign = |crf_sel_i[ALIGN_W-1:0];
    ill_n    = (op == OP_RSVD) || (is_cmp && misalign);
    trap_n   = !ill_n && (op == OP_OCMP) && any_nan;
    if (op == OP_CLASS)
      code_n = cls_code;
    else if (any_nan)
      code_n = CC_UN;
    else
      code_n = ord_code;
    crw_n = is_cmp && !ill_n && !trap_n;
    stw_n = !ill_n && !trap_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done_o    <= 1'b0;
      cr_we_o   <= 1'b0;
      st_we_o   <= 1'b0;
      trap_o    <= 1'b0;
      illegal_o <= 1'b0;
      code_o    <= '0;
      fld_o     <= '0;
      stat_o    <= '0;
    end else begin
      done_o    <= valid_i;
      cr_we_o   <= valid_i && crw_n;
      st_we_o   <= valid_i && stw_n;
      trap_o    <= valid_i && trap_n;
      illegal_o <= valid_i && ill_n;
      if (valid_i) begin
        code_o <= code_n;
        fld_o  <= crf_sel_i[SEL_W-1:ALIGN_W];
        stat_o <= {1'b0, code_n};
      end
    end
  end

endmodule

// File: rtl/fpc_chk.sv
module fpc_chk #(
  parameter int EXP_W   = 11,
  parameter int FRAC_W  = 52,
  parameter int SEL_W   = 5,
  parameter int ALIGN_W = 2
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     valid_i,
  input logic [1:0]               op_i,
  input logic [EXP_W+FRAC_W:0]    a_i,
  input logic [EXP_W+FRAC_W:0]    b_i,
  input logic [SEL_W-1:0]         crf_sel_i,
  input logic                     done_o,
  input logic [3:0]               code_o,
  input logic [SEL_W-ALIGN_W-1:0] fld_o,
  input logic                     cr_we_o,
  input logic                     st_we_o,
  input logic [4:0]               stat_o,
  input logic                     trap_o,
  input logic                     illegal_o
);
  localparam int MAG_W = EXP_W + FRAC_W;

  AST_TRAP_IS_UNORDERED: assert property (@(posedge clk) disable iff (rst)
    trap_o |-> code_o == 4'b0001); // R1

  AST_COMPARE_ONE_HOT: assert property (@(posedge clk) disable iff (rst)
    (cr_we_o && !$past(op_i[1])) |-> $countones(code_o) == 1); // R2

  AST_ZEROS_EQUAL: assert property (@(posedge clk) disable iff (rst)
    (st_we_o && $past(op_i[1] == 1'b0 && a_i[MAG_W-1:0] == '0 && b_i[MAG_W-1:0] == '0))
    |-> code_o == 4'b0010); // R3

  AST_TRAP_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    trap_o |-> (!cr_we_o && !st_we_o)); // R4

  AST_UCMP_NO_TRAP: assert property (@(posedge clk) disable iff (rst)
    (done_o && $past(op_i) == 2'b00) |-> !trap_o); // R5

  AST_FIELD_FROM_SEL: assert property (@(posedge clk) disable iff (rst)
    cr_we_o |-> fld_o == $past(crf_sel_i[SEL_W-1:ALIGN_W])); // R6

  AST_ILLEGAL_SILENT: assert property (@(posedge clk) disable iff (rst)
    illegal_o |-> (!cr_we_o && !st_we_o && !trap_o)); // R6

  AST_CLASS_BIT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    st_we_o |-> (stat_o[4] == 1'b0 && stat_o[3:0] == code_o)); // R7

  AST_CLASSIFY_STATUS_ONLY: assert property (@(posedge clk) disable iff (rst)
    (done_o && $past(op_i) == 2'b10) |-> (!cr_we_o && !trap_o && st_we_o)); // R8

  AST_DONE_FOLLOWS_VALID: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $past(valid_i)); // R9

  AST_FLAGS_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    (cr_we_o || st_we_o || trap_o || illegal_o) |-> done_o); // R9

  AST_RESERVED_ILLEGAL: assert property (@(posedge clk) disable iff (rst)
    (done_o && $past(op_i) == 2'b11) |-> illegal_o); // R10

endmodule

bind fp_cmp_unit fpc_chk #(
  .EXP_W(EXP_W), .FRAC_W(FRAC_W), .SEL_W(SEL_W), .ALIGN_W(ALIGN_W)
) u_fpc_chk (
  .clk(clk), .rst(rst), .valid_i(valid_i), .op_i(op_i), .a_i(a_i), .b_i(b_i),
  .crf_sel_i(crf_sel_i), .done_o(done_o), .code_o(code_o), .fld_o(fld_o),
  .cr_we_o(cr_we_o), .st_we_o(st_we_o), .stat_o(stat_o), .trap_o(trap_o),
  .illegal_o(illegal_o)
);

// File: tb/tb_fp_cmp_unit.sv
module tb_fp_cmp_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NVAL = 14;

  logic        clk = 1'b0;
  logic        rst;
  logic        valid_i;
  logic [1:0]  op_i;
  logic [63:0] a_i, b_i;
  logic [4:0]  crf_sel_i;
  logic        done_o, cr_we_o, st_we_o, trap_o, illegal_o;
  logic [3:0]  code_o;
  logic [2:0]  fld_o;
  logic [4:0]  stat_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fp_cmp_unit dut (
    .clk(clk), .rst(rst), .valid_i(valid_i), .op_i(op_i), .a_i(a_i), .b_i(b_i),
    .crf_sel_i(crf_sel_i), .done_o(done_o), .code_o(code_o), .fld_o(fld_o),
    .cr_we_o(cr_we_o), .st_we_o(st_we_o), .stat_o(stat_o), .trap_o(trap_o),
    .illegal_o(illegal_o)
  );

  function automatic logic [63:0] pat(int i);
    case (i)
      0:  pat = 64'h0000_0000_0000_0000; // +0
      1:  pat = 64'h8000_0000_0000_0000; // -0
      2:  pat = 64'h3FF0_0000_0000_0000; // +1
      3:  pat = 64'hBFF0_0000_0000_0000; // -1
      4:  pat = 64'h4000_0000_0000_0000; // +2
      5:  pat = 64'hC000_0000_0000_0000; // -2
      6:  pat = 64'h7FF0_0000_0000_0000; // +inf
      7:  pat = 64'hFFF0_0000_0000_0000; // -inf
      8:  pat = 64'h7FF8_0000_0000_0000; // quiet NaN
      9:  pat = 64'h7FF0_0000_0000_0001; // signalling NaN
      10: pat = 64'hFFF8_0000_0000_0000; // negative NaN
      11: pat = 64'h0000_0000_0000_0001; // smallest subnormal
      12: pat = 64'hFFEF_FFFF_FFFF_FFFF; // most negative finite
      default: pat = 64'h3FF8_0000_0000_0000; // +1.5
    endcase
  endfunction

  function automatic bit is_nan(logic [63:0] v);
    is_nan = (v[62:52] == 11'h7FF) && (v[51:0] != 0);
  endfunction

  task automatic check(string req, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // issue one operation and compare every output against the requirement model
  task automatic run_op(logic [1:0] op, logic [63:0] a, logic [63:0] b, logic [4:0] sel,
                        string req);
    real ra, rb;
    bit nan_any, ill, trp, crw, stw;
    logic [3:0] ec;
    @(negedge clk);
    op_i = op; a_i = a; b_i = b; crf_sel_i = sel; valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
    ra = $bitstoreal(a);
    rb = $bitstoreal(b);
    ill = (op == 2'b11) || (op != 2'b10 && sel[1:0] != 2'b00);
    if (op == 2'b10) begin
      nan_any = 1'b0;
      if (is_nan(a))      ec = 4'b0101;
      else if (ra == 0.0) ec = 4'b0010;
      else if (ra < 0.0)  ec = 4'b1000;
      else                ec = 4'b0100;
    end else begin
      nan_any = is_nan(a) || is_nan(b);
      if (nan_any)       ec = 4'b0001;
      else if (ra < rb)  ec = 4'b1000;
      else if (ra > rb)  ec = 4'b0100;
      else               ec = 4'b0010;
    end
    trp = !ill && op == 2'b01 && nan_any;
    crw = !ill && !trp && op[1] == 1'b0;
    stw = !ill && !trp;
    check({req, "/R9"}, "done", {7'd0, done_o}, 8'd1);
    check({req, "/R6"}, "illegal", {7'd0, illegal_o}, {7'd0, ill});
    check({req, "/R4"}, "trap", {7'd0, trap_o}, {7'd0, trp});
    check({req, "/R5"}, "cr_we", {7'd0, cr_we_o}, {7'd0, crw});
    check({req, "/R8"}, "st_we", {7'd0, st_we_o}, {7'd0, stw});
    if (!ill) check(req, "code", {4'd0, code_o}, {4'd0, ec});
    if (crw) check("R6", "field", {5'd0, fld_o}, {5'd0, sel[4:2]});
    if (stw) check("R7", "status", {3'd0, stat_o}, {3'd0, 1'b0, ec});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; valid_i = 1'b0; op_i = 2'b00; a_i = '0; b_i = '0; crf_sel_i = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state, R9
    check("R9", "reset done", {7'd0, done_o}, 8'd0);
    check("R9", "reset flags", {4'd0, cr_we_o, st_we_o, trap_o, illegal_o}, 8'd0);
    check("R9", "reset code", {4'd0, code_o}, 8'd0);

    // R1 R2 R3: all pairs under both compare flavours, aligned selectors
    for (int i = 0; i < NVAL; i++)
      for (int j = 0; j < NVAL; j++)
        for (int m = 0; m < 2; m++)
          run_op(m[1:0], pat(i), pat(j), 5'(((i + j) % 8) * 4), "R1R2R3");

    // R8: classification, selector must have no effect
    for (int i = 0; i < NVAL; i++)
      for (int s = 0; s < 4; s++)
        run_op(2'b10, pat(i), pat(8), 5'(s * 7 + 1), "R8");

    // R6: every selector value, ordered NaN and unordered ordinary operands
    for (int s = 0; s < 32; s++) begin
      run_op(2'b00, pat(3), pat(2), 5'(s), "R6");
      run_op(2'b01, pat(9), pat(2), 5'(s), "R6");
    end

    // R10: reserved operation
    for (int s = 0; s < 4; s++)
      run_op(2'b11, pat(s), pat(s + 1), 5'(s * 8), "R10");

    // R9: done and enables drop one cycle after a lone strobe
    run_op(2'b00, pat(2), pat(4), 5'd4, "R9");
    @(negedge clk);
    check("R9", "done drop", {7'd0, done_o}, 8'd0);
    check("R9", "flags drop", {4'd0, cr_we_o, st_we_o, trap_o, illegal_o}, 8'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule